// File: doc/BRIEF.md
# Crosspoint Routing Configuration Core

This block keeps the routing map of a 68-output, 68-input crosspoint and drives the selector array that it controls. Each data output is a combinational selector: it passes the current value of exactly one chosen input, or a constant 0 when it is switched off. A further selector, separate from the data outputs, picks one input to feed an activity-monitor pin.

Programming is done in steps. A write strobe latches an input code and an output code. A load strobe then places that pair into a staging bank. A configure strobe copies the whole staging bank into the live map in a single clock. With the broadcast control held high, a single load places the latched input into the staging entry of every data output. A level-sensitive initialise input forces both banks to the straight-through map. All strobes act on their rising edge, sampled by `clk`, and only while the active-low chip select is low.

Top module: `xpoint_route_core`

## Requirements
- R1: Each bit of `data_out[o]` equals `data_in[s]`, where s is the live selection for output o. A change on `data_in` reaches the output in the same cycle, with no clock edge in between.
- R2: A rising edge of `wr_strb` latches `in_code` and `out_code`. A later rising edge of `load_strb` puts the latched input code into the staging entry of the latched output. Neither step changes any output.
- R3: A rising edge of `cfg_strb` copies every staging entry into the live map in the same clock. The outputs then show all queued assignments together. Without that edge the live map stays unchanged.
- R4: While `cs_n` is high, edges on `wr_strb`, `load_strb` and `cfg_strb` have no effect.
- R5: While `init_map` is high, both the staging and the live map are set to input o for output o (o = 0..67) and to input 0 for the monitor. This wins over a load or a configure edge in the same cycle. Reset gives the same map.
- R6: Input code 7'h7F turns a selection off: the output drives a constant 0.
- R7: A load with a latched input code from 68 to 126 is ignored. A load with a latched output code from 69 to 127 is also ignored. In both cases the staging bank stays unchanged.
- R8: With `burst_en` high, a single load writes the latched input code into the staging entries of all 68 data outputs. The monitor entry is not changed.
- R9: Output code 68 addresses the monitor selector. It is staged and applied like a data output, and `mon_out` follows the chosen input (or drives 0 when the selection is off).
- R10: When a load and a configure edge fall in the same cycle, the live map takes the staging contents as they were before that load. The newly loaded entry goes live at the next configure edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Programming clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_in | input | 68 | Crosspoint data inputs |
| data_out | output | 68 | Crosspoint data outputs |
| mon_out | output | 1 | Activity-monitor selector output |
| in_code | input | 7 | Input-channel code (7'h7F = off) |
| out_code | input | 7 | Output-channel code (68 = monitor) |
| wr_strb | input | 1 | Code latch strobe, rising edge |
| cs_n | input | 1 | Active-low chip select |
| load_strb | input | 1 | Staging write strobe, rising edge |
| cfg_strb | input | 1 | Staging-to-live copy strobe, rising edge |
| burst_en | input | 1 | Load writes to all data outputs |
| init_map | input | 1 | Force straight-through map, level |

## Verification
The case that needs the most care is a load edge and a configure edge arriving in the same clock. The live map must take the staging bank as it stood before that load, while the staging bank takes the new entry. The bench raises both strobes in one step. It then checks that the addressed output still shows its old input, and that it moves to the new input only after a later configure edge. A second pairing, the initialise level together with a pending load and a configure edge, is provoked in the same way and judged against the straight-through map.

// File: rtl/xp_route_pkg.sv
package xp_route_pkg;
  localparam int CODE_W = 7;
  localparam logic [CODE_W-1:0] OFF_CODE = 7'h7F;
endpackage

// File: rtl/xp_prog_front.sv
module xp_prog_front #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          wr_strb,
  input  logic          load_strb,
  input  logic          cfg_strb,
  input  logic [CW-1:0] in_code,
  input  logic [CW-1:0] out_code,
  output logic          load_pulse,
  output logic          cfg_pulse,
  output logic [CW-1:0] hold_in,
  output logic [CW-1:0] hold_out
);
  logic wr_q, ld_q, cf_q;
  logic wr_rise;
  logic [CW-1:0] hold_in_nxt, hold_out_nxt;

  always_comb begin
    wr_rise      = wr_strb   & ~wr_q & ~cs_n;
    load_pulse   = load_strb & ~ld_q & ~cs_n;
    cfg_pulse    = cfg_strb  & ~cf_q & ~cs_n;
    hold_in_nxt  = hold_in;
    hold_out_nxt = hold_out;
    if (wr_rise) begin
      hold_in_nxt  = in_code;
      hold_out_nxt = out_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      ld_q     <= 1'b0;
      cf_q     <= 1'b0;
      hold_in  <= '0;
      hold_out <= '0;
    end else begin
      wr_q     <= wr_strb;
      ld_q     <= load_strb;
      cf_q     <= cfg_strb;
      hold_in  <= hold_in_nxt;
      hold_out <= hold_out_nxt;
    end
  end
endmodule

// File: rtl/xp_map_bank.sv
module xp_map_bank
  import xp_route_pkg::*;
#(
  parameter int N_IN  = 68,
  parameter int N_OUT = 68,
  parameter int CW    = 7,
  localparam int N_ENT = N_OUT + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                init_map,
  input  logic                burst_en,
  input  logic                load_pulse,
  input  logic                cfg_pulse,
  input  logic [CW-1:0]       hold_in,
  input  logic [CW-1:0]       hold_out,
  output logic [N_ENT*CW-1:0] stg_flat,
  output logic [N_ENT*CW-1:0] act_flat
);
  logic in_ok;
  assign in_ok = (hold_in < CW'(N_IN)) || (hold_in == OFF_CODE);

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    localparam bit IS_DATA = (e < N_OUT);
    localparam int ID_I = IS_DATA ? ((e < N_IN) ? e : int'(OFF_CODE)) : 0;
    localparam logic [CW-1:0] ID_CODE = CW'(ID_I);

    logic [CW-1:0] stg_q, stg_nxt, act_q, act_nxt;
    logic          hit;

    always_comb begin
      hit     = burst_en ? IS_DATA : (hold_out == CW'(e));
      stg_nxt = stg_q;
      act_nxt = act_q;
      if (init_map) begin
        stg_nxt = ID_CODE;
        act_nxt = ID_CODE;
      end else begin
        if (load_pulse && in_ok && hit) stg_nxt = hold_in;
        if (cfg_pulse) act_nxt = stg_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q <= ID_CODE;
        act_q <= ID_CODE;
      end else begin
        stg_q <= stg_nxt;
        act_q <= act_nxt;
      end
    end

    assign stg_flat[e*CW +: CW] = stg_q;
    assign act_flat[e*CW +: CW] = act_q;
  end
endmodule

// File: rtl/xp_sel_array.sv
module xp_sel_array #(
  parameter int N_IN  = 68,
  parameter int N_OUT = 68,
  parameter int CW    = 7,
  localparam int N_ENT = N_OUT + 1
) (
  input  logic [N_IN-1:0]     data_in,
  input  logic [N_ENT*CW-1:0] act_flat,
  output logic [N_OUT-1:0]    data_out,
  output logic                mon_out
);
  function automatic logic pick(input logic [CW-1:0] s, input logic [N_IN-1:0] d);
    logic r;
    r = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (s == CW'(i)) r = d[i];
    end
    return r;
  endfunction

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    assign data_out[o] = pick(act_flat[o*CW +: CW], data_in);
  end

  assign mon_out = pick(act_flat[N_OUT*CW +: CW], data_in);
endmodule

// File: rtl/xpoint_route_core.sv
module xpoint_route_core #(
  parameter int N_IN  = 68,
  parameter int N_OUT = 68
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  data_in,
  output logic [N_OUT-1:0] data_out,
  output logic             mon_out,
  input  logic [6:0]       in_code,
  input  logic [6:0]       out_code,
  input  logic             wr_strb,
  input  logic             cs_n,
  input  logic             load_strb,
  input  logic             cfg_strb,
  input  logic             burst_en,
  input  logic             init_map
);
  localparam int CW    = xp_route_pkg::CODE_W;
  localparam int N_ENT = N_OUT + 1;

  logic                load_pulse, cfg_pulse;
  logic [CW-1:0]       hold_in, hold_out;
  logic [N_ENT*CW-1:0] stg_flat, act_flat;

  xp_prog_front #(.CW(CW)) u_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n),
    .wr_strb(wr_strb), .load_strb(load_strb), .cfg_strb(cfg_strb),
    .in_code(in_code), .out_code(out_code),
    .load_pulse(load_pulse), .cfg_pulse(cfg_pulse),
    .hold_in(hold_in), .hold_out(hold_out)
  );

  xp_map_bank #(.N_IN(N_IN), .N_OUT(N_OUT), .CW(CW)) u_bank (
    .clk(clk), .rst_n(rst_n), .init_map(init_map), .burst_en(burst_en),
    .load_pulse(load_pulse), .cfg_pulse(cfg_pulse),
    .hold_in(hold_in), .hold_out(hold_out),
    .stg_flat(stg_flat), .act_flat(act_flat)
  );

  xp_sel_array #(.N_IN(N_IN), .N_OUT(N_OUT), .CW(CW)) u_sel (
    .data_in(data_in), .act_flat(act_flat),
    .data_out(data_out), .mon_out(mon_out)
  );
endmodule

// File: rtl/xp_route_chk.sv
module xp_route_chk #(
  parameter int N_IN  = 68,
  parameter int N_OUT = 68,
  parameter int CW    = 7,
  localparam int N_ENT = N_OUT + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_n,
  input logic                init_map,
  input logic                burst_en,
  input logic                load_pulse,
  input logic                cfg_pulse,
  input logic [CW-1:0]       hold_in,
  input logic [N_ENT*CW-1:0] stg_flat,
  input logic [N_ENT*CW-1:0] act_flat,
  input logic [N_OUT-1:0]    data_out
);
  logic [N_OUT-1:0] off_mask;
  logic             in_ok;

  for (genvar o = 0; o < N_OUT; o++) begin : g_off
    assign off_mask[o] = (act_flat[o*CW +: CW] == {CW{1'b1}});
  end
  assign in_ok = (hold_in < CW'(N_IN)) || (hold_in == {CW{1'b1}});

  // R3
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_pulse && !init_map) |=> $stable(act_flat));

  // R3
  act_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pulse && !init_map) |=> (act_flat == $past(stg_flat)));

  // R4
  cs_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!load_pulse && !cfg_pulse));

  // R5
  init_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_map |=> (act_flat == stg_flat));

  // R6
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((data_out & off_mask) == '0));

  // R7
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && !in_ok && !init_map) |=> $stable(stg_flat));

  // R8
  burst_mon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pulse && burst_en && !init_map) |=> $stable(stg_flat[N_OUT*CW +: CW]));
endmodule

bind xpoint_route_core xp_route_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .init_map(init_map), .burst_en(burst_en),
  .load_pulse(load_pulse), .cfg_pulse(cfg_pulse), .hold_in(hold_in),
  .stg_flat(stg_flat), .act_flat(act_flat), .data_out(data_out)
);

// File: tb/xpoint_route_core_test.sv
`timescale 1ns/100ps
module xpoint_route_core_test;
  localparam int NI = 68;
  localparam int NO = 68;

  logic clk = 1'b0;
  logic rst_n;
  logic [NI-1:0] data_in;
  logic [NO-1:0] data_out;
  logic mon_out;
  logic [6:0] in_code, out_code;
  logic wr_strb, cs_n, load_strb, cfg_strb, burst_en, init_map;

  int tests = 0;
  int fails = 0;
  bit live = 1'b0;

  always #2.5 clk = ~clk;

  xpoint_route_core #(.N_IN(NI), .N_OUT(NO)) uut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .data_out(data_out), .mon_out(mon_out),
    .in_code(in_code), .out_code(out_code), .wr_strb(wr_strb), .cs_n(cs_n),
    .load_strb(load_strb), .cfg_strb(cfg_strb), .burst_en(burst_en), .init_map(init_map)
  );

  // behavioural reference: staging and live selections per entry (68 = monitor)
  int m_stg[NO+1];
  int m_act[NO+1];
  int m_hin, m_hout;
  bit p_wr, p_ld, p_cf;

  always @(posedge clk or negedge rst_n) begin
    int old_stg[NO+1];
    bit w, l, c, ok;
    if (!rst_n) begin
      for (int e = 0; e <= NO; e++) begin
        m_stg[e] = (e == NO) ? 0 : e;
        m_act[e] = m_stg[e];
      end
      m_hin = 0; m_hout = 0; p_wr = 0; p_ld = 0; p_cf = 0;
    end else begin
      w = wr_strb && !p_wr && !cs_n;
      l = load_strb && !p_ld && !cs_n;
      c = cfg_strb && !p_cf && !cs_n;
      old_stg = m_stg;
      if (init_map) begin
        for (int e = 0; e <= NO; e++) begin
          m_stg[e] = (e == NO) ? 0 : e;
          m_act[e] = m_stg[e];
        end
      end else begin
        ok = (m_hin < NI) || (m_hin == 127);
        if (l && ok) begin
          if (burst_en) begin
            for (int e = 0; e < NO; e++) m_stg[e] = m_hin;
          end else if (m_hout <= NO) begin
            m_stg[m_hout] = m_hin;
          end
        end
        if (c) m_act = old_stg;
      end
      if (w) begin
        m_hin = int'(in_code);
        m_hout = int'(out_code);
      end
      p_wr = wr_strb; p_ld = load_strb; p_cf = cfg_strb;
    end
  end

  function automatic logic pick_ref(int s);
    return (s < NI) ? data_in[s] : 1'b0;
  endfunction

  // per-cycle comparison against the reference (R1, R6, R9)
  always @(negedge clk) begin
    logic [NO-1:0] exp_o;
    logic exp_m;
    if (live) begin
      for (int o = 0; o < NO; o++) exp_o[o] = pick_ref(m_act[o]);
      exp_m = pick_ref(m_act[NO]);
      tests++;
      if (data_out !== exp_o || mon_out !== exp_m) begin
        fails++;
        $display("FAIL R1 per-cycle map: actual=%h/%b expected=%h/%b", data_out, mon_out, exp_o, exp_m);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [NO-1:0] act, input logic [NO-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    data_in = NI'({$urandom(), $urandom(), $urandom()});
  endtask

  task automatic wr_pair(input int i, input int o);
    in_code = 7'(i); out_code = 7'(o); wr_strb = 1'b1;
    step();
    wr_strb = 1'b0; load_strb = 1'b1;
    step();
    load_strb = 1'b0;
    step();
  endtask

  task automatic do_cfg();
    cfg_strb = 1'b1;
    step();
    cfg_strb = 1'b0;
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; data_in = '0; in_code = '0; out_code = '0;
    wr_strb = 0; cs_n = 0; load_strb = 0; cfg_strb = 0; burst_en = 0; init_map = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; live = 1'b1;
    step();
    @(negedge clk);
    // R5 reset gives straight-through
    chk(data_out == data_in && mon_out == data_in[0], "R5 reset identity", data_out, data_in);

    // R2 staged only
    wr_pair(3, 10);
    @(negedge clk);
    chk(data_out[10] == data_in[10], "R2 staged not live", {67'b0, data_out[10]}, {67'b0, data_in[10]});
    do_cfg();
    @(negedge clk);
    chk(data_out[10] == data_in[3], "R3 cfg applies", {67'b0, data_out[10]}, {67'b0, data_in[3]});

    // R3 several queued together
    wr_pair(5, 0); wr_pair(6, 1); wr_pair(7, 67);
    @(negedge clk);
    chk(data_out[0] == data_in[0] && data_out[67] == data_in[67], "R3 queue held", data_out, data_in);
    do_cfg();
    @(negedge clk);
    chk(data_out[0] == data_in[5] && data_out[1] == data_in[6] && data_out[67] == data_in[7],
        "R3 queue applied", data_out, data_in);

    // R4 chip select high blocks writes and configure
    cs_n = 1'b1;
    wr_pair(9, 0); do_cfg();
    @(negedge clk);
    chk(data_out[0] == data_in[5], "R4 cs high ignored", {67'b0, data_out[0]}, {67'b0, data_in[5]});
    cs_n = 1'b0;
    do_cfg();
    @(negedge clk);
    chk(data_out[0] == data_in[5], "R4 no stale staging", {67'b0, data_out[0]}, {67'b0, data_in[5]});

    // R6 disable code
    wr_pair(127, 2); do_cfg();
    data_in = '1; #0.5;
    chk(data_out[2] == 1'b0, "R6 off drives 0", {67'b0, data_out[2]}, '0);

    // R7 out-of-range codes
    wr_pair(70, 4); wr_pair(126, 4); wr_pair(8, 100); do_cfg();
    @(negedge clk);
    chk(data_out[4] == data_in[4], "R7 bad input code ignored", {67'b0, data_out[4]}, {67'b0, data_in[4]});

    // R9 monitor through out code 68
    wr_pair(12, 68);
    @(negedge clk);
    chk(mon_out == data_in[0], "R9 monitor staged only", {67'b0, mon_out}, {67'b0, data_in[0]});
    do_cfg();
    @(negedge clk);
    chk(mon_out == data_in[12], "R9 monitor applied", {67'b0, mon_out}, {67'b0, data_in[12]});

    // R8 burst
    burst_en = 1'b1;
    wr_pair(20, 0);
    burst_en = 1'b0;
    do_cfg();
    @(negedge clk);
    chk(data_out == {NO{data_in[20]}} && mon_out == data_in[12], "R8 burst all outputs",
        data_out, {NO{data_in[20]}});

    // R10 load and configure in the same cycle
    in_code = 7'd30; out_code = 7'd5; wr_strb = 1'b1;
    step();
    wr_strb = 1'b0; load_strb = 1'b1; cfg_strb = 1'b1;
    step();
    load_strb = 1'b0; cfg_strb = 1'b0;
    step();
    @(negedge clk);
    chk(data_out[5] == data_in[20], "R10 same-cycle old staging", {67'b0, data_out[5]}, {67'b0, data_in[20]});
    do_cfg();
    @(negedge clk);
    chk(data_out[5] == data_in[30], "R10 entry live next cfg", {67'b0, data_out[5]}, {67'b0, data_in[30]});

    // R5 initialise beats same-cycle load and configure
    in_code = 7'd40; out_code = 7'd6; wr_strb = 1'b1;
    step();
    wr_strb = 1'b0; load_strb = 1'b1; cfg_strb = 1'b1; init_map = 1'b1;
    step();
    load_strb = 1'b0; cfg_strb = 1'b0; init_map = 1'b0;
    step();
    @(negedge clk);
    chk(data_out == data_in && mon_out == data_in[0], "R5 init identity", data_out, data_in);
    do_cfg();
    @(negedge clk);
    chk(data_out == data_in, "R5 staging also identity", data_out, data_in);

    repeat (4) step();
    live = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule